// File: doc/BRIEF.md
# Register Bank Context Switch Sequencer

This block performs the register bank exchange that follows a rewrite of the context pointer. The pointer names the memory area that backs the global bank of sixteen word registers. A trigger carries the old and the new pointer values. There are two kinds of trigger: a switch-context instruction, or a pop whose destination is the context pointer.

For a switch-context trigger the block first pushes the old pointer to the system stack and then writes the new pointer. For a pop it writes the new pointer in a single step. In both cases a fixed background sequence follows, and that sequence is charged as a stall to the next instruction. First the live register contents are saved to the old bank area, in pairs of words. Then the new bank is read back from memory into the register file. A few penalty cycles complete the sequence.

The trigger is a valid/ready channel. Once `trig_valid` is raised, the requester holds it and keeps `trig_pop`, `trig_old_cp` and `trig_new_cp` stable until a cycle in which `trig_ready` is high; that cycle is the handshake. `trig_ready` is high only while the sequencer is idle, so a trigger that arrives during a sequence waits. The memory and register-file ports are plain and have a fixed timing: memory writes complete in their cycle, and read data appears on `mem_rdata` in the cycle after the read.

Top module: `ctxsw_seq`

## Requirements
- R1: `trig_ready` is 1 exactly when the sequencer is idle. A trigger is accepted on a rising edge where `trig_valid` and `trig_ready` are both 1.
- R2: For a switch-context trigger (`trig_pop`=0), the cycle after acceptance is the push. In that cycle `mem_en`=1, `mem_we`=1 and `mem_pair`=0. `mem_addr` and `sp_next` both equal `sp_cur`-2, and `sp_we`=1. `mem_wdata` holds the old pointer in bits 15:0 and zero in bits 31:16.
- R3: For a switch-context trigger, the cycle after the push has `cp_we`=1 with `cp_wdata` equal to the new pointer, and `stall`=0.
- R4: For a pop trigger (`trig_pop`=1), `cp_we`=1 with the new pointer in the cycle right after acceptance. No push is made and `sp_we` stays 0.
- R5: The store phase covers the 8 cycles after the pointer write. In store cycle k (0..7), `rf_ridx`=k and the block drives a paired write (`mem_en`=1, `mem_we`=1, `mem_pair`=1). The write goes to old pointer + 4k, and `mem_wdata` carries register 2k in bits 15:0 and register 2k+1 in bits 31:16.
- R6: The load phase covers the 8 cycles after the store phase. In load cycle k the block issues a paired read at new pointer + 4k. In the next cycle `rf_we`=1, `rf_widx`=k and `rf_wdata`=`mem_rdata`.
- R7: `stall` is 1 for exactly 24 consecutive cycles, starting in the cycle after the pointer write, and is 0 at all other times.
- R8: After reset, `trig_ready`=1 and `stall`, `cp_we`, `sp_we`, `mem_en` and `rf_we` are all 0. A reset in the middle of a sequence returns the block to this state.
- R9: A trigger held valid during a sequence has no effect until the sequencer is idle again. It is accepted in the first idle cycle, and its pointer write comes one cycle (pop) or two cycles (switch-context) after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger request valid |
| trig_ready | output | 1 | Sequencer idle, trigger may be taken |
| trig_pop | input | 1 | 1: pop into pointer, 0: switch-context instruction |
| trig_old_cp | input | 16 | Pointer value before the rewrite |
| trig_new_cp | input | 16 | Pointer value after the rewrite |
| sp_cur | input | 16 | Current system stack pointer |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_next | output | 16 | Updated stack pointer |
| cp_we | output | 1 | Context pointer write strobe |
| cp_wdata | output | 16 | New context pointer value |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_pair | output | 1 | 1: two-word transfer, 0: single word in bits 15:0 |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| rf_ridx | output | 3 | Register pair read index |
| rf_rdata | input | 32 | Register pair contents (combinational) |
| rf_we | output | 1 | Register pair write strobe |
| rf_widx | output | 3 | Register pair write index |
| rf_wdata | output | 32 | Register pair write data |
| stall | output | 1 | Hold the following instruction |

## Verification
The assertions assume that a requester keeps `trig_valid` and its payload steady until the handshake. They also assume that `sp_cur` does not change while a push is being issued, and that memory read data arrives with exactly one cycle of latency. The bench drives every trigger and stack value at the falling edge. It changes the payload only after a handshake, and its memory model registers read data one edge after each read.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_PUSH,
    CS_CPWR,
    CS_STORE,
    CS_LOAD,
    CS_TAIL
  } cs_state_e;

endpackage

// File: rtl/ctxsw_ctrl.sv
module ctxsw_ctrl
  import ctxsw_pkg::*;
#(
  parameter int XFERS    = 8,
  parameter int TAIL_LEN = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_valid,
  input  logic             trig_pop,
  output logic             trig_ready,
  output logic             accept,
  output cs_state_e        state,
  output logic [CNT_W-1:0] cnt,
  output logic             stall
);

  localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(XFERS - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_LEN - 1);

  cs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign trig_ready = (state_q == CS_IDLE);
  assign accept     = trig_valid && trig_ready;
  assign state      = state_q;
  assign cnt        = cnt_q;
  assign stall      = (state_q == CS_STORE) || (state_q == CS_LOAD) ||
                      (state_q == CS_TAIL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CS_IDLE: begin
        cnt_d = '0;
        if (accept) state_d = trig_pop ? CS_CPWR : CS_PUSH;
      end
      CS_PUSH: state_d = CS_CPWR;
      CS_CPWR: begin
        state_d = CS_STORE;
        cnt_d   = '0;
      end
      CS_STORE: begin
        if (cnt_q == XFER_LAST) begin
          state_d = CS_LOAD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CS_LOAD: begin
        if (cnt_q == XFER_LAST) begin
          state_d = CS_TAIL;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CS_TAIL: begin
        if (cnt_q == TAIL_LAST) begin
          state_d = CS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = CS_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R4 / R2: the first step after a handshake is chosen by the trigger kind
  a_r4_pop_skips_push: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && trig_pop) |=> (state_q == CS_CPWR));
  a_r2_switch_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !trig_pop) |=> (state_q == CS_PUSH));
  // R7: the stall window opens right after the pointer write
  a_r7_stall_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_CPWR) |=> stall);

endmodule

// File: rtl/ctxsw_addr_gen.sv
module ctxsw_addr_gen
  import ctxsw_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int CNT_W   = 4,
  parameter int STEP_SH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [PTR_W-1:0] trig_old,
  input  logic [PTR_W-1:0] trig_new,
  input  logic [PTR_W-1:0] sp_cur,
  input  cs_state_e        state,
  input  logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] old_q,
  output logic [PTR_W-1:0] new_q,
  output logic [PTR_W-1:0] sp_dec,
  output logic [PTR_W-1:0] mem_addr
);

  logic [PTR_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_q <= '0;
      new_q <= '0;
    end else if (accept) begin
      old_q <= trig_old;
      new_q <= trig_new;
    end
  end

  assign sp_dec = sp_cur - PTR_W'(2);
  assign offset = PTR_W'(cnt) << STEP_SH;

  always_comb begin
    unique case (state)
      CS_PUSH:  mem_addr = sp_dec;
      CS_STORE: mem_addr = old_q + offset;
      CS_LOAD:  mem_addr = new_q + offset;
      default:  mem_addr = '0;
    endcase
  end

  // R5 / R6: consecutive transfers of one phase step by one pair
  a_r5_store_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_STORE && $past(state) == CS_STORE) |->
      (mem_addr == $past(mem_addr) + PTR_W'(1 << STEP_SH)));
  a_r6_load_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_LOAD && $past(state) == CS_LOAD) |->
      (mem_addr == $past(mem_addr) + PTR_W'(1 << STEP_SH)));

endmodule

// File: rtl/ctxsw_load_pipe.sv
module ctxsw_load_pipe #(
  parameter int IDX_W  = 3,
  parameter int XFER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_issue,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [XFER_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_widx,
  output logic [XFER_W-1:0] rf_wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we   <= 1'b0;
      rf_widx <= '0;
    end else begin
      rf_we   <= ld_issue;
      rf_widx <= ld_idx;
    end
  end

  assign rf_wdata = mem_rdata;

  // R6: register writes come in an unbroken run, one pair index apart
  a_r6_write_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && $past(rf_we)) |-> (rf_widx == $past(rf_widx) + 1'b1));

endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int NUM_REGS      = 16,
  parameter int REGS_PER_XFER = 2,
  parameter int SWITCH_STALL  = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            trig_valid,
  output logic                            trig_ready,
  input  logic                            trig_pop,
  input  logic [WORD_W-1:0]               trig_old_cp,
  input  logic [WORD_W-1:0]               trig_new_cp,
  input  logic [WORD_W-1:0]               sp_cur,
  output logic                            sp_we,
  output logic [WORD_W-1:0]               sp_next,
  output logic                            cp_we,
  output logic [WORD_W-1:0]               cp_wdata,
  output logic                            mem_en,
  output logic                            mem_we,
  output logic                            mem_pair,
  output logic [WORD_W-1:0]               mem_addr,
  output logic [WORD_W*REGS_PER_XFER-1:0] mem_wdata,
  input  logic [WORD_W*REGS_PER_XFER-1:0] mem_rdata,
  output logic [$clog2(NUM_REGS/REGS_PER_XFER)-1:0] rf_ridx,
  input  logic [WORD_W*REGS_PER_XFER-1:0] rf_rdata,
  output logic                            rf_we,
  output logic [$clog2(NUM_REGS/REGS_PER_XFER)-1:0] rf_widx,
  output logic [WORD_W*REGS_PER_XFER-1:0] rf_wdata,
  output logic                            stall
);

  localparam int XFERS      = NUM_REGS / REGS_PER_XFER;
  localparam int XFER_W     = WORD_W * REGS_PER_XFER;
  localparam int IDX_W      = $clog2(XFERS);
  localparam int TAIL_LEN   = SWITCH_STALL - 2 * XFERS;
  localparam int CNT_MAX    = (XFERS > TAIL_LEN) ? XFERS : TAIL_LEN;
  localparam int CNT_W      = $clog2(CNT_MAX) + 1;
  localparam int XFER_BYTES = XFER_W / 8;
  localparam int STEP_SH    = $clog2(XFER_BYTES);
  localparam int RUN_W      = $clog2(SWITCH_STALL + 1) + 1;

  cs_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic [WORD_W-1:0] old_q, new_q, sp_dec;
  logic             in_push, in_store, in_load;

  ctxsw_ctrl #(
    .XFERS    (XFERS),
    .TAIL_LEN (TAIL_LEN),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_pop   (trig_pop),
    .trig_ready (trig_ready),
    .accept     (accept),
    .state      (state),
    .cnt        (cnt),
    .stall      (stall)
  );

  ctxsw_addr_gen #(
    .PTR_W   (WORD_W),
    .CNT_W   (CNT_W),
    .STEP_SH (STEP_SH)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .trig_old (trig_old_cp),
    .trig_new (trig_new_cp),
    .sp_cur   (sp_cur),
    .state    (state),
    .cnt      (cnt),
    .old_q    (old_q),
    .new_q    (new_q),
    .sp_dec   (sp_dec),
    .mem_addr (mem_addr)
  );

  assign in_push  = (state == CS_PUSH);
  assign in_store = (state == CS_STORE);
  assign in_load  = (state == CS_LOAD);

  ctxsw_load_pipe #(
    .IDX_W  (IDX_W),
    .XFER_W (XFER_W)
  ) u_ldpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_issue  (in_load),
    .ld_idx    (cnt[IDX_W-1:0]),
    .mem_rdata (mem_rdata),
    .rf_we     (rf_we),
    .rf_widx   (rf_widx),
    .rf_wdata  (rf_wdata)
  );

  assign sp_we    = in_push;
  assign sp_next  = sp_dec;
  assign cp_we    = (state == CS_CPWR);
  assign cp_wdata = new_q;
  assign mem_en   = in_push || in_store || in_load;
  assign mem_we   = in_push || in_store;
  assign mem_pair = in_store || in_load;
  assign rf_ridx  = cnt[IDX_W-1:0];

  // The pushed word sits in the low lane; wider transfers zero the rest.
  generate
    if (XFER_W > WORD_W) begin : g_wide
      assign mem_wdata = in_push ? {{(XFER_W-WORD_W){1'b0}}, old_q} : rf_rdata;
    end else begin : g_narrow
      assign mem_wdata = in_push ? old_q : rf_rdata;
    end
  endgenerate

  // Checker state: length of the current stall run
  logic [RUN_W-1:0] stall_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     stall_run_q <= '0;
    else if (stall) stall_run_q <= stall_run_q + 1'b1;
    else            stall_run_q <= '0;
  end

  // R7: each stall run is exactly SWITCH_STALL cycles long
  a_r7_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_run_q < RUN_W'(SWITCH_STALL)));
  a_r7_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && stall_run_q != '0) |-> (stall_run_q == RUN_W'(SWITCH_STALL)));
  // R1: no handshake while the following instruction is held
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !trig_ready);
  // R2: the push write and the stack pointer update agree
  a_r2_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !mem_pair) |-> (sp_we && sp_next == mem_addr));
  // R3: the pointer write follows the push
  a_r3_cp_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !mem_pair) |=> (cp_we && !stall));
  // R6: every paired read is written back one cycle later
  a_r6_read_writes_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> rf_we);
  // R8: pointer write and memory traffic never share a cycle
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cp_we, mem_en}));

endmodule

// File: tb/test_ctxsw_seq.sv
`timescale 1ns/1ps
module test_ctxsw_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic        trig_pop = 1'b0;
  logic [15:0] trig_old_cp = '0;
  logic [15:0] trig_new_cp = '0;
  logic [15:0] sp_cur = '0;
  logic        sp_we;
  logic [15:0] sp_next;
  logic        cp_we;
  logic [15:0] cp_wdata;
  logic        mem_en, mem_we, mem_pair;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  rf_ridx;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_widx;
  logic [31:0] rf_wdata;
  logic        stall;

  int checks = 0;
  int failures = 0;
  logic [15:0] rf [16];
  logic [15:0] exp_rf [16];

  always #2 clk = ~clk;

  ctxsw_seq i_ctxsw_seq (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_pop(trig_pop), .trig_old_cp(trig_old_cp), .trig_new_cp(trig_new_cp),
    .sp_cur(sp_cur), .sp_we(sp_we), .sp_next(sp_next), .cp_we(cp_we),
    .cp_wdata(cp_wdata), .mem_en(mem_en), .mem_we(mem_we), .mem_pair(mem_pair),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_ridx(rf_ridx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_widx(rf_widx),
    .rf_wdata(rf_wdata), .stall(stall)
  );

  function automatic logic [31:0] pat(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  // memory: one-cycle read latency; register file: combinational read
  always @(posedge clk) if (mem_en && !mem_we) mem_rdata <= pat(mem_addr);
  always @(posedge clk) if (rf_we) begin
    rf[2*rf_widx]   <= rf_wdata[15:0];
    rf[2*rf_widx+1] <= rf_wdata[31:16];
  end
  always_comb rf_rdata = {rf[2*rf_ridx+1], rf[2*rf_ridx]};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_expect(input logic [15:0] base);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] p;
      p = pat(base + 16'(4*k));
      exp_rf[2*k]   = p[15:0];
      exp_rf[2*k+1] = p[31:16];
    end
  endtask

  // One full sequence; starts and ends just after a falling edge.
  task automatic run_seq(input logic pop, input logic [15:0] oldp,
                         input logic [15:0] newp, input logic [15:0] spv);
    trig_pop = pop; trig_old_cp = oldp; trig_new_cp = newp; sp_cur = spv;
    trig_valid = 1'b1;
    chk(trig_ready == 1'b1, "R1 ready when idle", 32'(trig_ready), 32'd1);
    @(negedge clk);
    trig_valid = 1'b0;
    if (!pop) begin
      chk(mem_en && mem_we && !mem_pair, "R2 push kind",
          {29'd0, mem_en, mem_we, mem_pair}, 32'd6);
      chk(mem_addr == spv - 16'd2, "R2 push addr", 32'(mem_addr), 32'(spv - 16'd2));
      chk(mem_wdata == {16'd0, oldp}, "R2 push data", mem_wdata, {16'd0, oldp});
      chk(sp_we && sp_next == spv - 16'd2, "R2 sp update", 32'(sp_next),
          32'(spv - 16'd2));
      chk(!stall, "R7 no stall on push", 32'(stall), 32'd0);
      @(negedge clk);
    end
    chk(cp_we && cp_wdata == newp, pop ? "R4 pop pointer write" : "R3 pointer write",
        32'(cp_wdata), 32'(newp));
    chk(!stall && !mem_en, "R3 no stall at pointer write", {mem_en, stall}, 32'd0);
    if (pop) chk(!sp_we, "R4 no stack update", 32'(sp_we), 32'd0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(stall, "R7 stall in store", 32'(stall), 32'd1);
      chk(mem_en && mem_we && mem_pair && rf_ridx == 3'(k), "R5 store kind",
          {mem_en, mem_we, mem_pair, rf_ridx}, {3'b111, 3'(k)});
      chk(mem_addr == oldp + 16'(4*k), "R5 store addr", 32'(mem_addr),
          32'(oldp + 16'(4*k)));
      chk(mem_wdata == {exp_rf[2*k+1], exp_rf[2*k]}, "R5 store data", mem_wdata,
          {exp_rf[2*k+1], exp_rf[2*k]});
    end
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk(stall, "R7 stall in load", 32'(stall), 32'd1);
      if (k < 8) begin
        chk(mem_en && !mem_we && mem_pair, "R6 load kind",
            {mem_en, mem_we, mem_pair}, 32'b101);
        chk(mem_addr == newp + 16'(4*k), "R6 load addr", 32'(mem_addr),
            32'(newp + 16'(4*k)));
      end else begin
        chk(!mem_en, "R6 no access after loads", 32'(mem_en), 32'd0);
      end
      if (k > 0) begin
        chk(rf_we && rf_widx == 3'(k-1), "R6 rf write idx", {rf_we, rf_widx},
            {1'b1, 3'(k-1)});
        chk(rf_wdata == pat(newp + 16'(4*(k-1))), "R6 rf write data", rf_wdata,
            pat(newp + 16'(4*(k-1))));
      end
    end
    for (int t = 1; t < 8; t++) begin
      @(negedge clk);
      chk(stall && !rf_we && !mem_en, "R7 tail stall", {rf_we, mem_en, stall},
          32'd1);
    end
    @(negedge clk);
    chk(!stall && trig_ready, "R7 stall ends after 24", {stall, trig_ready}, 32'd1);
    load_expect(newp);
    for (int i = 0; i < 16; i++)
      chk(rf[i] == exp_rf[i], "R6 bank loaded", 32'(rf[i]), 32'(exp_rf[i]));
  endtask

  localparam int NV = 4;
  // {pop, old, new, sp}
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 16'hF600, 16'hF620, 16'hFC00},
    {1'b1, 16'hF620, 16'hF640, 16'hFC00},
    {1'b0, 16'hF640, 16'h0100, 16'h0002},
    {1'b0, 16'h0100, 16'hFFE0, 16'h8000}
  };

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 16'h1000 + 16'(i * 16'h111);
      exp_rf[i] = rf[i];
    end
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(trig_ready && !stall && !cp_we && !sp_we && !mem_en && !rf_we,
        "R8 reset state", {trig_ready, stall, cp_we, sp_we, mem_en, rf_we},
        32'b100000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_seq(VEC[v][48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);

    // R9: trigger held valid while busy
    trig_pop = 1'b0; trig_old_cp = 16'h2000; trig_new_cp = 16'h2100;
    sp_cur = 16'h7000; trig_valid = 1'b1;
    @(negedge clk);
    trig_pop = 1'b1; trig_old_cp = 16'h2100; trig_new_cp = 16'h3300;
    for (int n = 2; n <= 27; n++) begin
      @(negedge clk);
      if (n >= 3) chk(!cp_we, "R9 held trigger ignored", 32'(cp_we), 32'd0);
      if (n < 27) chk(!trig_ready, "R9 not ready while busy", 32'(trig_ready), 32'd0);
      else        chk(trig_ready, "R9 ready when idle again", 32'(trig_ready), 32'd1);
    end
    @(negedge clk);
    trig_valid = 1'b0;
    chk(cp_we && cp_wdata == 16'h3300, "R9 held trigger taken", 32'(cp_wdata),
        32'h3300);
    repeat (26) @(negedge clk);
    chk(!stall && trig_ready, "R9 second sequence done", {stall, trig_ready}, 32'd1);
    load_expect(16'h2100);
    load_expect(16'h3300);
    for (int i = 0; i < 16; i++)
      chk(rf[i] == exp_rf[i], "R9 bank after both", 32'(rf[i]), 32'(exp_rf[i]));

    // R8: reset in the middle of a sequence
    trig_pop = 1'b0; trig_old_cp = 16'h3300; trig_new_cp = 16'h4000;
    trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(stall, "R7 stall mid sequence", 32'(stall), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(trig_ready && !stall && !cp_we && !sp_we && !mem_en && !rf_we,
        "R8 reset mid sequence", {trig_ready, stall, cp_we, sp_we, mem_en, rf_we},
        32'b100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!stall && !mem_en, "R8 stays idle", {stall, mem_en}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule